// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a compact 32-bit processor core that spreads every instruction over several clock cycles. It executes register-to-register arithmetic and logic, word loads, word stores, an equality branch and an absolute jump. The core has no separate incrementer or branch-target adder. One arithmetic unit produces the sequential program counter during fetch and the speculative branch target during decode. A single memory port serves both instruction fetches and data accesses. Holding registers sit between memory, the register file and the arithmetic unit, so no clock cycle contains more than one of these three operations.

The core connects to a single word-addressed memory through an address, write data, read data and two strobes. Reads are combinational from the core's point of view: data returned on `mem_rdata` during a cycle with `mem_rd` high is captured at the end of that cycle. A write happens at the clock edge that ends a cycle in which `mem_wr` is high. The active-low reset is applied asynchronously. Its release is retimed through a two-stage synchronizer, so the first instruction fetch completes on the third rising clock edge after `rst_n` goes high.

Top module: `mc_core`

## Requirements
- R1: While reset is in effect, and until the synchronizer has released it (on the second rising edge after `rst_n` goes high), the core holds the fetch of address 0: `mem_rd`=1, `mem_wr`=0, `mem_addr`=0.
- R2: Each instruction begins with one fetch cycle in which `mem_rd`=1 and `mem_addr` equals the program counter. When no branch is taken and no jump occurs, the next fetch is at that address plus 4.
- R3: Instruction lengths in cycles are: load 5, store 4, register arithmetic 4, branch 3, jump 3. Outside fetch, `mem_rd` is high only in the 4th cycle of a load, and `mem_wr` is high only in the 4th cycle of a store.
- R4: The effective address of a load or store is register rs (bits 25:21) plus the sign-extended 16-bit immediate (bits 15:0). It appears on `mem_addr` in the 4th cycle. The load opcode is 0x23 and the store opcode is 0x2B (bits 31:26).
- R5: A store drives the value of register rt (bits 20:16) on `mem_wdata` in its write cycle.
- R6: A load writes the addressed memory word into register rt.
- R7: Opcode 0x00 selects register arithmetic. It writes register rd (bits 15:11) with a result chosen by the function field (bits 5:0): 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0).
- R8: A branch uses opcode 0x04. When rs equals rt, the next fetch is at (branch address + 4) + (sign-extended immediate × 4). Otherwise the next fetch is at branch address + 4.
- R9: A jump uses opcode 0x02. The next fetch is at the upper 4 bits of (jump address + 4), followed by the 26-bit field in bits 25:0, followed by two zero bits.
- R10: Register 0 always reads as zero, and any write to it has no effect.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| mem_addr | output | DW | Memory word address (byte address, word aligned) |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Memory read data, sampled at the end of a read cycle |
| mem_rd | output | 1 | Read strobe (instruction fetch or load) |
| mem_wr | output | 1 | Write strobe (store) |

## Verification
The bench builds the core with its defaults: a 32-bit data path and a two-stage reset synchronizer. With the two-stage synchronizer, the exact edge at which the first fetch completes can be observed. The full 32-bit width lets signed set-less-than operate on a negative operand, lets an effective address be formed from a negative base register, and lets a backward branch use a negative offset. The program mixes taken and untaken branches, a forward jump over a skipped store, and a write to register 0. A behavioural model predicts the strobes, addresses and store data on every cycle.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OPC_ARITH = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BREQ  = 6'h04;
  localparam logic [5:0] OPC_JUMP  = 6'h02;

  localparam logic [5:0] FUN_ADD = 6'h20;
  localparam logic [5:0] FUN_SUB = 6'h22;
  localparam logic [5:0] FUN_AND = 6'h24;
  localparam logic [5:0] FUN_OR  = 6'h25;
  localparam logic [5:0] FUN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    S_FETCH,
    S_DECODE,
    S_ADDR,
    S_LDMEM,
    S_LDWB,
    S_STMEM,
    S_EXEC,
    S_EXWB,
    S_BRANCH,
    S_JUMP
  } state_e;

  typedef enum logic [1:0] {
    SB_REGB,
    SB_FOUR,
    SB_IMM,
    SB_IMMX4
  } srcb_e;

  typedef enum logic [1:0] {
    PS_ALU,
    PS_HELD,
    PS_JUMP
  } pcsel_e;

  typedef enum logic [1:0] {
    AO_ADD,
    AO_SUB,
    AO_FUNC
  } aluop_e;

  typedef enum logic [2:0] {
    AF_ADD,
    AF_SUB,
    AF_AND,
    AF_OR,
    AF_SLT
  } alufn_e;

  typedef struct packed {
    logic   addr_from_hold;
    logic   mem_rd;
    logic   mem_wr;
    logic   ir_en;
    logic   reg_en;
    logic   dst_is_rd;
    logic   wb_from_mdr;
    logic   srca_reg;
    srcb_e  srcb;
    aluop_e aluop;
    logic   pc_en;
    logic   pc_en_eq;
    pcsel_e pcsel;
  } ctrl_t;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_sel_a,
  input  logic [AW-1:0] rd_sel_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] store_q [NREG];

  // entry 0 is never written; reads of index 0 are forced to zero
  always_ff @(posedge clk) begin
    if (wr_en && (wr_sel != '0)) begin
      store_q[wr_sel] <= wr_data;
    end
  end

  assign rd_data_a = (rd_sel_a == '0) ? '0 : store_q[rd_sel_a];
  assign rd_data_b = (rd_sel_b == '0) ? '0 : store_q[rd_sel_b];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  aluop_e        aluop,
  input  logic [5:0]    funct,
  output logic [DW-1:0] res,
  output logic          zero
);

  alufn_e fn;

  always_comb begin
    case (aluop)
      AO_ADD:  fn = AF_ADD;
      AO_SUB:  fn = AF_SUB;
      default: begin
        case (funct)
          FUN_SUB: fn = AF_SUB;
          FUN_AND: fn = AF_AND;
          FUN_OR:  fn = AF_OR;
          FUN_SLT: fn = AF_SLT;
          default: fn = AF_ADD;
        endcase
      end
    endcase
  end

  always_comb begin
    case (fn)
      AF_SUB:  res = opa - opb;
      AF_AND:  res = opa & opb;
      AF_OR:   res = opa | opb;
      AF_SLT:  res = {{(DW-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = opa + opb;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output state_e     state,
  output ctrl_t      ctl
);

  state_e state_q;
  state_e state_d;

  always_comb begin
    case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OPC_LOAD, OPC_STORE: state_d = S_ADDR;
          OPC_ARITH:           state_d = S_EXEC;
          OPC_BREQ:            state_d = S_BRANCH;
          OPC_JUMP:            state_d = S_JUMP;
          default:             state_d = S_FETCH;
        endcase
      end
      S_ADDR:   state_d = (opcode == OPC_LOAD) ? S_LDMEM : S_STMEM;
      S_LDMEM:  state_d = S_LDWB;
      S_EXEC:   state_d = S_EXWB;
      default:  state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.srcb  = SB_REGB;
    ctl.aluop = AO_ADD;
    ctl.pcsel = PS_ALU;
    case (state_q)
      S_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_en  = 1'b1;
        ctl.srcb   = SB_FOUR;
        ctl.pc_en  = 1'b1;
      end
      S_DECODE: begin
        ctl.srcb = SB_IMMX4;
      end
      S_ADDR: begin
        ctl.srca_reg = 1'b1;
        ctl.srcb     = SB_IMM;
      end
      S_LDMEM: begin
        ctl.addr_from_hold = 1'b1;
        ctl.mem_rd         = 1'b1;
      end
      S_LDWB: begin
        ctl.reg_en      = 1'b1;
        ctl.wb_from_mdr = 1'b1;
      end
      S_STMEM: begin
        ctl.addr_from_hold = 1'b1;
        ctl.mem_wr         = 1'b1;
      end
      S_EXEC: begin
        ctl.srca_reg = 1'b1;
        ctl.aluop    = AO_FUNC;
      end
      S_EXWB: begin
        ctl.reg_en    = 1'b1;
        ctl.dst_is_rd = 1'b1;
      end
      S_BRANCH: begin
        ctl.srca_reg = 1'b1;
        ctl.aluop    = AO_SUB;
        ctl.pc_en_eq = 1'b1;
        ctl.pcsel    = PS_HELD;
      end
      S_JUMP: begin
        ctl.pc_en = 1'b1;
        ctl.pcsel = PS_JUMP;
      end
      default: ;
    endcase
  end

  assign state = state_q;

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr
);

  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  // reset release retiming
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= (rst_pipe << 1) | RST_STAGES'(1);
    end
  end

  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  // holding registers
  logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, hold_q;
  logic [DW-1:0] pc_d;
  logic          pc_load;

  state_e state;
  ctrl_t  ctl;

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .opcode (ir_q[31:26]),
    .state  (state),
    .ctl    (ctl)
  );

  logic [RAW-1:0] f_rs, f_rt, f_rd;
  logic [DW-1:0]  imm_ext;
  logic [DW-1:0]  jump_tgt;

  assign f_rs     = ir_q[25:21];
  assign f_rt     = ir_q[20:16];
  assign f_rd     = ir_q[15:11];
  assign imm_ext  = {{(DW-16){ir_q[15]}}, ir_q[15:0]};
  assign jump_tgt = {pc_q[DW-1:28], ir_q[25:0], 2'b00};

  // register file
  logic [DW-1:0]  rf_a, rf_b, wb_data;
  logic [RAW-1:0] wb_sel;

  assign wb_sel  = ctl.dst_is_rd ? f_rd : f_rt;
  assign wb_data = ctl.wb_from_mdr ? mdr_q : hold_q;

  mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rd_sel_a  (f_rs),
    .rd_sel_b  (f_rt),
    .rd_data_a (rf_a),
    .rd_data_b (rf_b),
    .wr_en     (ctl.reg_en),
    .wr_sel    (wb_sel),
    .wr_data   (wb_data)
  );

  // shared arithmetic unit
  logic [DW-1:0] alu_a, alu_b, alu_y;
  logic          alu_zero;

  assign alu_a = ctl.srca_reg ? a_q : pc_q;

  always_comb begin
    case (ctl.srcb)
      SB_FOUR:  alu_b = DW'(4);
      SB_IMM:   alu_b = imm_ext;
      SB_IMMX4: alu_b = imm_ext << 2;
      default:  alu_b = b_q;
    endcase
  end

  mc_alu #(.DW(DW)) u_alu (
    .opa   (alu_a),
    .opb   (alu_b),
    .aluop (ctl.aluop),
    .funct (ir_q[5:0]),
    .res   (alu_y),
    .zero  (alu_zero)
  );

  // program counter next value and enable
  always_comb begin
    case (ctl.pcsel)
      PS_HELD: pc_d = hold_q;
      PS_JUMP: pc_d = jump_tgt;
      default: pc_d = alu_y;
    endcase
  end

  assign pc_load = ctl.pc_en | (ctl.pc_en_eq & alu_zero);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
    end else if (pc_load) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ir_q <= '0;
    end else if (ctl.ir_en) begin
      ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mdr_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      hold_q <= '0;
    end else begin
      mdr_q  <= mem_rdata;
      a_q    <= rf_a;
      b_q    <= rf_b;
      hold_q <= alu_y;
    end
  end

  // memory port
  assign mem_addr  = ctl.addr_from_hold ? hold_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input state_e        state,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] ir,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] b_q,
  input logic [DW-1:0] hold_q,
  input logic [DW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr
);

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |-> (mem_rd && (mem_addr == pc)));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |=> (pc == $past(pc) + DW'(4)));

  assert_store_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (state == S_FETCH));

  assert_jump_tgt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_JUMP) |=> (pc == {$past(pc[DW-1:28]), $past(ir[25:0]), 2'b00}));

  assert_br_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BRANCH && a_q != b_q) |=> $stable(pc));

  assert_br_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BRANCH && a_q == b_q) |=> (pc == $past(hold_q)));

  assert_zero_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE && ir[25:21] == 5'd0) |=> (a_q == '0));

endmodule

bind mc_core mc_core_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .state    (state),
  .pc       (pc_q),
  .ir       (ir_q),
  .a_q      (a_q),
  .b_q      (b_q),
  .hold_q   (hold_q),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/mc_core_test.sv
module mc_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 256;

  localparam logic [5:0] T_ARITH = 6'h00;
  localparam logic [5:0] T_LOAD  = 6'h23;
  localparam logic [5:0] T_STORE = 6'h2B;
  localparam logic [5:0] T_BREQ  = 6'h04;
  localparam logic [5:0] T_JUMP  = 6'h02;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  logic [31:0] mem [WORDS];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {T_ARITH, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // behavioural reference model
  logic [31:0] m_pc, m_ir, m_ea, m_nxt;
  logic [31:0] m_reg [32];
  int          phase, rel_cnt;
  string       ftag;
  logic [5:0]  op;
  logic        exp_rd, exp_wr;

  function automatic int ilen(input logic [5:0] o);
    case (o)
      T_LOAD:           return 5;
      T_STORE, T_ARITH: return 4;
      T_BREQ, T_JUMP:   return 3;
      default:          return 2;
    endcase
  endfunction

  function automatic logic [31:0] arith(input logic [5:0] fn, input logic [31:0] x, input logic [31:0] y);
    case (fn)
      6'h22:   return x - y;
      6'h24:   return x & y;
      6'h25:   return x | y;
      6'h2A:   return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return x + y;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      rel_cnt = 0;
      phase   = 0;
      m_pc    = 32'd0;
      ftag    = "R1";
      for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    end else begin
      rel_cnt++;
    end
    if (phase == 0) m_ir = mem[m_pc[9:2]];
    op     = m_ir[31:26];
    exp_rd = (phase == 0) || (op == T_LOAD && phase == 3);
    exp_wr = (phase == 3) && (op == T_STORE);
    chk("R3", "read strobe", {31'd0, mem_rd}, {31'd0, exp_rd});
    chk("R11", "write strobe", {31'd0, mem_wr}, {31'd0, exp_wr});
    if (phase == 0) chk(ftag, "fetch address", mem_addr, m_pc);
    m_ea = m_reg[m_ir[25:21]] + {{16{m_ir[15]}}, m_ir[15:0]};
    if (phase == 3 && (op == T_LOAD || op == T_STORE))
      chk("R4", "data address", mem_addr, m_ea);
    if (phase == 3 && op == T_STORE)
      chk("R5", "store data", mem_wdata, m_reg[m_ir[20:16]]);
    if (rst_n && rel_cnt >= 2) begin
      phase++;
      if (phase == ilen(op)) begin
        phase = 0;
        m_nxt = m_pc + 32'd4;
        ftag  = "R2";
        case (op)
          T_ARITH: if (m_ir[15:11] != 5'd0)
                     m_reg[m_ir[15:11]] = arith(m_ir[5:0], m_reg[m_ir[25:21]], m_reg[m_ir[20:16]]);
          T_LOAD:  if (m_ir[20:16] != 5'd0) m_reg[m_ir[20:16]] = mem[m_ea[9:2]];
          T_BREQ: begin
            ftag = "R8";
            if (m_reg[m_ir[25:21]] == m_reg[m_ir[20:16]])
              m_nxt = m_nxt + ({{16{m_ir[15]}}, m_ir[15:0]} << 2);
          end
          T_JUMP: begin
            ftag  = "R9";
            m_nxt = {m_nxt[31:28], m_ir[25:0], 2'b00};
          end
          default: ;
        endcase
        m_pc = m_nxt;
      end
    end
  end

  initial begin
    rst_n = 1'b1;
    for (int i = 0; i < WORDS; i++) mem[i] = 32'd0;
    mem[0]  = enc_i(T_LOAD, 0, 1, 16'h0100);
    mem[1]  = enc_i(T_LOAD, 0, 2, 16'h0104);
    mem[2]  = enc_i(T_LOAD, 0, 3, 16'h0108);
    mem[3]  = enc_i(T_LOAD, 0, 4, 16'h010C);
    mem[4]  = enc_r(1, 2, 5, 6'h20);
    mem[5]  = enc_r(1, 2, 6, 6'h22);
    mem[6]  = enc_r(3, 4, 7, 6'h24);
    mem[7]  = enc_r(3, 4, 8, 6'h25);
    mem[8]  = enc_r(2, 1, 9, 6'h2A);
    mem[9]  = enc_r(1, 2, 10, 6'h2A);
    mem[10] = enc_r(1, 1, 0, 6'h20);
    mem[11] = enc_i(T_STORE, 0, 5, 16'h0140);
    mem[12] = enc_i(T_STORE, 0, 6, 16'h0144);
    mem[13] = enc_i(T_STORE, 0, 7, 16'h0148);
    mem[14] = enc_i(T_STORE, 0, 8, 16'h014C);
    mem[15] = enc_i(T_STORE, 0, 9, 16'h0150);
    mem[16] = enc_i(T_STORE, 0, 10, 16'h0154);
    mem[17] = enc_i(T_STORE, 0, 0, 16'h0158);
    mem[18] = enc_i(T_BREQ, 1, 2, 16'h0005);
    mem[19] = enc_i(T_BREQ, 1, 1, 16'h0002);
    mem[20] = enc_i(T_STORE, 0, 1, 16'h015C);
    mem[21] = enc_i(T_STORE, 0, 1, 16'h015C);
    mem[22] = enc_i(T_LOAD, 1, 11, 16'h015B);
    mem[23] = enc_i(T_STORE, 0, 11, 16'h0164);
    mem[24] = enc_i(T_STORE, 2, 1, 16'h016B);
    mem[25] = {T_JUMP, 26'd27};
    mem[26] = enc_i(T_STORE, 0, 1, 16'h016C);
    mem[27] = enc_i(T_BREQ, 0, 0, 16'hFFFF);
    mem[64] = 32'h0000_0005;
    mem[65] = 32'hFFFF_FFFD;
    mem[66] = 32'h0F0F_00FF;
    mem[67] = 32'h00FF_0F0F;
    mem[85] = 32'h3333_3333;
    mem[86] = 32'hDEAD_BEEF;
    mem[87] = 32'h1111_1111;
    mem[88] = 32'h1234_5678;
    mem[91] = 32'h2222_2222;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk("R7", "add result", mem[80], 32'h0000_0002);
    chk("R7", "sub result", mem[81], 32'h0000_0008);
    chk("R7", "and result", mem[82], 32'h000F_000F);
    chk("R7", "or result", mem[83], 32'h0FFF_0FFF);
    chk("R7", "slt true", mem[84], 32'h0000_0001);
    chk("R7", "slt false", mem[85], 32'h0000_0000);
    chk("R10", "register 0 stored", mem[86], 32'h0000_0000);
    chk("R8", "skipped store untouched", mem[87], 32'h1111_1111);
    chk("R6", "loaded word forwarded", mem[89], 32'h1234_5678);
    chk("R4", "negative base store", mem[90], 32'h0000_0005);
    chk("R9", "jumped-over store untouched", mem[91], 32'h2222_2222);
    chk("R8", "halt loop address", m_pc, 32'h0000_006C);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule